// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

A synthesizable model of a small synchronous static RAM whose bus can carry a new read or write on every clock, including a write straight after a read and a read straight after a write. All commands, addresses and byte write enables are sampled on the rising clock edge. Each write takes its data from the shared data bus a fixed number of cycles after the command. That delay matches the delay of read data, so the bus never needs an idle cycle to change direction.

A static strap selects one of two timing variants. In pipelined mode read data passes through an output register, and write data follows its command by two clocks. In flow-through mode read data leaves the array directly, and write data follows by one clock. A second strap selects the order of addresses in a four-beat burst: either wrapping increment or XOR on the two low address bits. An output enable and a sleep input can release the data bus at any moment.

The command controller is a three-state machine. IDLE moves to READ or WRITE on a load with all enables true. READ and WRITE stay in place and step the beat on an advance. Any state goes to IDLE on a load that is deselected, and on any edge where sleep is high. IDLE stays in IDLE on an advance.

Top module: `zt_sram`

## Requirements
- R1: A load (`adv`=0) starts an access only when `cs_n_a`=0, `cs_b`=1 and `cs_n_c`=0 and `sleep`=0. `wr_en`=1 makes it a write and `wr_en`=0 makes it a read. A load with any enable false is a deselect: it writes nothing and drives nothing. An advance (`adv`=1) while no burst is active is also a deselect.
- R2: Read data for a read access sampled at edge t is driven on `dq` after edge t+1 in pipelined mode (`flow_sel`=0). In flow-through mode (`flow_sel`=1) it is driven right after edge t. It stays on `dq` for one cycle.
- R3: For a write access sampled at edge t, the data word is taken from `dq` at edge t+2 in pipelined mode and at edge t+1 in flow-through mode.
- R4: Reads and writes can alternate on consecutive edges in any mix with no idle cycle. The block never drives `dq` in a cycle whose data it is about to capture.
- R5: With `ilv_sel`=0, each advance moves to the next beat k of the burst. The beat address is the start address with its two low bits replaced by (start[1:0]+k) mod 4. The type of access (read or write) is kept. Beats past the fourth wrap around.
- R6: With `ilv_sel`=1, the two low bits of the beat address are start[1:0] XOR k.
- R7: `bwe[b]`=1 writes byte b, which is `dq[9b+8:9b]` (8 data bits plus 1 parity bit). Bytes with `bwe[b]`=0 keep their old value. `bwe` is sampled on the same edge as the load or advance it belongs to.
- R8: A read of a word whose write data has not yet been stored returns the new data for the enabled bytes and the old data for the others.
- R9: `oe`=0 releases `dq` at once, without waiting for a clock edge. Raising `oe` again during the same data cycle drives the data again.
- R10: While `sleep`=1, commands are ignored, the burst ends and `dq` is released. Stored data is kept, and writes already accepted still take their data.
- R11: `rst_n`=0 returns the controller to IDLE and discards pending writes and read data. `dq` is released. Memory contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | AW (6) | Word address, sampled on a load |
| cs_n_a | input | 1 | Chip enable, active low |
| cs_b | input | 1 | Chip enable, active high |
| cs_n_c | input | 1 | Chip enable, active low |
| wr_en | input | 1 | 1 = write, 0 = read, sampled on a load |
| adv | input | 1 | 1 = advance the burst, 0 = load a new command |
| bwe | input | NB (2) | Byte write enables, active high |
| ilv_sel | input | 1 | Burst order strap: 0 linear, 1 interleaved |
| flow_sel | input | 1 | Timing strap: 0 pipelined, 1 flow-through |
| oe | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Ignore commands and release the bus |
| dq | inout | NB*9 (18) | Bidirectional data bus |

## Verification
In pipelined mode read data is due in the cycle after the edge following its command, and in flow-through mode in the cycle right after the command edge. Write data is due on the bus at the second edge after its command (pipelined) or the first (flow-through). The bench's reference model keeps pending writes and pending reads in queues, each entry tagged with the edge at which it becomes due. At every edge it first stores the writes that are due, and only then reads out the reads that are due, which gives the forwarding order for free. `dq` is compared in the middle of the low clock phase. It is compared a second time right after the inputs change, which catches any late response to `oe` and `sleep`. When the bench expects the block to be silent, it drives the bus itself with either the next write word or zero. Any stray drive from the block then shows up as a wrong value.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    // Access performed during the current cycle
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } acc_state_e;

endpackage

// File: rtl/zt_cmd_fsm.sv
module zt_cmd_fsm
    import zt_sram_pkg::*;
#(
    parameter int AW        = 6,
    parameter int BURST_LEN = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep,
    input  logic          sel_ok,
    input  logic          adv,
    input  logic          wr_en,
    input  logic          ilv_sel,
    input  logic [AW-1:0] addr,
    output logic          rd_acc,
    output logic          wr_acc,
    output logic [AW-1:0] acc_addr
);
    localparam int OW = $clog2(BURST_LEN);

    acc_state_e      st_q, st_d;
    logic [AW-1:0]   base_q, base_d;
    logic [OW-1:0]   beat_q, beat_d;
    logic [OW-1:0]   off;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            base_q <= '0;
            beat_q <= '0;
        end else begin
            st_q   <= st_d;
            base_q <= base_d;
            beat_q <= beat_d;
        end
    end

    // Next-state logic
    always_comb begin
        st_d   = st_q;
        base_d = base_q;
        beat_d = beat_q;
        if (sleep) begin
            st_d = ST_IDLE;
        end else if (!adv) begin
            if (sel_ok) begin
                st_d   = wr_en ? ST_WRITE : ST_READ;
                base_d = addr;
                beat_d = '0;
            end else begin
                st_d = ST_IDLE;
            end
        end else begin
            unique case (st_q)
                ST_READ, ST_WRITE: beat_d = beat_q + 1'b1;
                default:           st_d   = ST_IDLE;
            endcase
        end
    end

    // Outputs: access type and beat address
    always_comb begin
        off      = ilv_sel ? (base_q[OW-1:0] ^ beat_q) : (base_q[OW-1:0] + beat_q);
        acc_addr = {base_q[AW-1:OW], off};
        rd_acc   = (st_q == ST_READ);
        wr_acc   = (st_q == ST_WRITE);
    end

    AST_SLEEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (st_q == ST_IDLE)); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && adv && !sleep) |=> (st_q == ST_IDLE)); // R1
    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && adv && !sleep) |=>
            (beat_q == $past(beat_q) + 1'b1) && $stable(base_q) && $stable(st_q)); // R5

endmodule

// File: rtl/zt_late_write.sv
module zt_late_write #(
    parameter int AW = 6,
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flow_sel,
    input  logic          wr_acc,
    input  logic [AW-1:0] acc_addr,
    input  logic [NB-1:0] bwe,
    output logic          cm_valid,
    output logic [AW-1:0] cm_addr,
    output logic [NB-1:0] cm_be
);
    logic [NB-1:0] be_q;
    logic          s2_v_q;
    logic [AW-1:0] s2_addr_q;
    logic [NB-1:0] s2_be_q;

    // Byte enables travel with the access they were sampled with
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            be_q      <= '0;
            s2_v_q    <= 1'b0;
            s2_addr_q <= '0;
            s2_be_q   <= '0;
        end else begin
            be_q      <= bwe;
            s2_v_q    <= wr_acc;
            s2_addr_q <= acc_addr;
            s2_be_q   <= be_q;
        end
    end

    // Stage whose data is on the bus this cycle
    always_comb begin
        if (flow_sel) begin
            cm_valid = wr_acc;
            cm_addr  = acc_addr;
            cm_be    = be_q;
        end else begin
            cm_valid = s2_v_q;
            cm_addr  = s2_addr_q;
            cm_be    = s2_be_q;
        end
    end

    AST_DOUBLE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_sel && wr_acc) |=>
            (cm_valid && cm_addr == $past(acc_addr) && cm_be == $past(be_q))); // R3

endmodule

// File: rtl/zt_store.sv
module zt_store #(
    parameter int AW     = 6,
    parameter int NB     = 2,
    parameter int BYTE_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flow_sel,
    input  logic               rd_acc,
    input  logic [AW-1:0]      acc_addr,
    input  logic               cm_valid,
    input  logic [AW-1:0]      cm_addr,
    input  logic [NB-1:0]      cm_be,
    input  logic [NB*BYTE_W-1:0] wdata,
    output logic [NB*BYTE_W-1:0] rd_data,
    output logic               rd_valid
);
    localparam int DW    = NB * BYTE_W;
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] mem_word;
    logic [DW-1:0] fwd_word;
    logic          fwd_hit;
    logic [DW-1:0] out_q;
    logic          out_v_q;

    // Byte-masked array write
    always_ff @(posedge clk) begin
        if (cm_valid) begin
            for (int b = 0; b < NB; b++) begin
                if (cm_be[b]) mem[cm_addr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
            end
        end
    end

    assign mem_word = mem[acc_addr];
    assign fwd_hit  = cm_valid && (cm_addr == acc_addr);

    // Merge bus data landing on the same edge, byte by byte
    for (genvar g = 0; g < NB; g++) begin : g_fwd
        assign fwd_word[g*BYTE_W +: BYTE_W] = (fwd_hit && cm_be[g]) ?
            wdata[g*BYTE_W +: BYTE_W] : mem_word[g*BYTE_W +: BYTE_W];
    end

    // Output register used in pipelined mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q   <= '0;
            out_v_q <= 1'b0;
        end else begin
            out_v_q <= rd_acc;
            if (rd_acc) out_q <= fwd_word;
        end
    end

    assign rd_data  = flow_sel ? mem_word : out_q;
    assign rd_valid = flow_sel ? rd_acc : out_v_q;

    AST_PIPE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_sel && out_v_q) |-> $past(rd_acc)); // R2
    AST_FWD_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_sel && rd_acc && fwd_hit && cm_be == {NB{1'b1}}) |=> (out_q == $past(wdata))); // R8

endmodule

// File: rtl/zt_sram.sv
module zt_sram #(
    parameter int AW        = 6,
    parameter int NB        = 2,
    parameter int BYTE_W    = 9,
    parameter int BURST_LEN = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        addr,
    input  logic                 cs_n_a,
    input  logic                 cs_b,
    input  logic                 cs_n_c,
    input  logic                 wr_en,
    input  logic                 adv,
    input  logic [NB-1:0]        bwe,
    input  logic                 ilv_sel,
    input  logic                 flow_sel,
    input  logic                 oe,
    input  logic                 sleep,
    inout  wire  [NB*BYTE_W-1:0] dq
);
    localparam int DW = NB * BYTE_W;

    logic          sel_ok;
    logic          rd_acc, wr_acc;
    logic [AW-1:0] acc_addr;
    logic          cm_valid;
    logic [AW-1:0] cm_addr;
    logic [NB-1:0] cm_be;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic          drive_en;

    assign sel_ok = !cs_n_a && cs_b && !cs_n_c;

    zt_cmd_fsm #(.AW(AW), .BURST_LEN(BURST_LEN)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .sel_ok(sel_ok), .adv(adv),
        .wr_en(wr_en), .ilv_sel(ilv_sel), .addr(addr),
        .rd_acc(rd_acc), .wr_acc(wr_acc), .acc_addr(acc_addr)
    );

    zt_late_write #(.AW(AW), .NB(NB)) u_lw (
        .clk(clk), .rst_n(rst_n), .flow_sel(flow_sel), .wr_acc(wr_acc),
        .acc_addr(acc_addr), .bwe(bwe),
        .cm_valid(cm_valid), .cm_addr(cm_addr), .cm_be(cm_be)
    );

    zt_store #(.AW(AW), .NB(NB), .BYTE_W(BYTE_W)) u_store (
        .clk(clk), .rst_n(rst_n), .flow_sel(flow_sel), .rd_acc(rd_acc),
        .acc_addr(acc_addr), .cm_valid(cm_valid), .cm_addr(cm_addr),
        .cm_be(cm_be), .wdata(dq), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // Asynchronous release by output enable and sleep
    assign drive_en = oe && !sleep && rd_valid;
    assign dq       = drive_en ? rd_data : {DW{1'bz}};

    AST_NO_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !cm_valid); // R4

endmodule

// File: tb/zt_sram_test.sv
`timescale 1ns/1ps
module zt_sram_test;
    localparam int AW = 6;
    localparam int NB = 2;
    localparam int BW = 9;
    localparam int DW = NB * BW;
    localparam int BL = 4;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          r_rst_n = 1'b0;
    logic [AW-1:0] r_addr = '0;
    logic          r_csa_n = 1'b1, r_csb = 1'b0, r_csc_n = 1'b1;
    logic          r_wr = 1'b0, r_adv = 1'b0;
    logic [NB-1:0] r_bwe = '0;
    logic          r_ilv = 1'b0, r_flow = 1'b0, r_oe = 1'b1, r_sleep = 1'b0;
    logic          tb_drv = 1'b1;
    logic [DW-1:0] tb_val = '0;
    wire  [DW-1:0] dq;

    assign dq = tb_drv ? tb_val : {DW{1'bz}};

    zt_sram uut (
        .clk(clk), .rst_n(r_rst_n), .addr(r_addr), .cs_n_a(r_csa_n), .cs_b(r_csb),
        .cs_n_c(r_csc_n), .wr_en(r_wr), .adv(r_adv), .bwe(r_bwe), .ilv_sel(r_ilv),
        .flow_sel(r_flow), .oe(r_oe), .sleep(r_sleep), .dq(dq)
    );

    // Reference model state
    logic [DW-1:0] mmem [DEPTH];
    int            wq_addr[$];
    logic [NB-1:0] wq_be[$];
    logic [DW-1:0] wq_data[$];
    int            wq_due[$];
    int            rq_addr[$];
    int            rq_eval[$];
    int            m_st = 0, m_base = 0, m_beat = 0;
    int            edge_n = 0;
    logic          rd_now = 1'b0;
    logic [DW-1:0] rd_val = '0;
    logic [DW-1:0] wnext = '0;
    logic          dut_exp = 1'b0;
    logic [31:0]   seed = 32'h1d2c3b4a;

    int    n_chk = 0, n_err = 0;
    string cur_req = "R11";

    function automatic logic [DW-1:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed[DW-1:0];
    endfunction

    // Behaviour at one rising edge, using the inputs held over that edge
    task automatic model_step();
        int a;
        edge_n++;
        if (!r_rst_n) begin
            wq_addr.delete(); wq_be.delete(); wq_data.delete(); wq_due.delete();
            rq_addr.delete(); rq_eval.delete();
            m_st = 0; rd_now = 1'b0; wnext = '0;
            return;
        end
        while (wq_due.size() > 0 && wq_due[0] == edge_n) begin
            for (int b = 0; b < NB; b++)
                if (wq_be[0][b]) mmem[wq_addr[0]][b*BW +: BW] = wq_data[0][b*BW +: BW];
            void'(wq_addr.pop_front()); void'(wq_be.pop_front());
            void'(wq_data.pop_front()); void'(wq_due.pop_front());
        end
        if (r_sleep) m_st = 0;
        else if (!r_adv) begin
            if (!r_csa_n && r_csb && !r_csc_n) begin
                m_st = r_wr ? 2 : 1; m_base = int'(r_addr); m_beat = 0;
            end else m_st = 0;
        end else if (m_st != 0) m_beat = (m_beat + 1) % BL;
        if (r_ilv) a = (m_base & ~(BL-1)) | ((m_base & (BL-1)) ^ m_beat);
        else       a = (m_base & ~(BL-1)) | (((m_base & (BL-1)) + m_beat) % BL);
        if (m_st == 1) begin
            rq_addr.push_back(a); rq_eval.push_back(edge_n + (r_flow ? 0 : 1));
        end else if (m_st == 2) begin
            wq_addr.push_back(a); wq_be.push_back(r_bwe);
            wq_data.push_back(rnd()); wq_due.push_back(edge_n + (r_flow ? 1 : 2));
        end
        rd_now = 1'b0;
        if (rq_eval.size() > 0 && rq_eval[0] == edge_n) begin
            rd_now = 1'b1; rd_val = mmem[rq_addr[0]];
            void'(rq_addr.pop_front()); void'(rq_eval.pop_front());
        end
        wnext = (wq_due.size() > 0 && wq_due[0] == edge_n + 1) ? wq_data[0] : '0;
    endtask

    task automatic set_drive();
        dut_exp = rd_now && r_oe && !r_sleep;
        tb_drv  = !dut_exp;
        tb_val  = wnext;
    endtask

    task automatic check();
        logic [DW-1:0] exp;
        exp = dut_exp ? rd_val : wnext;
        n_chk++;
        if (dq !== exp) begin
            n_err++;
            $display("FAIL %s edge %0d dq actual=%h expected=%h", cur_req, edge_n, dq, exp);
        end
    endtask

    task automatic advance();
        set_drive(); #1 check();
        @(negedge clk);
        model_step(); set_drive(); #1 check();
    endtask

    task automatic cmd(input logic ld, input logic we, input int a, input logic [NB-1:0] be);
        r_csa_n = 1'b0; r_csb = 1'b1; r_csc_n = 1'b0;
        r_adv = !ld; r_wr = we; r_addr = a[AW-1:0]; r_bwe = be;
        advance();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            r_adv = 1'b0; r_csb = 1'b0; r_wr = 1'b0; r_bwe = '0;
            advance();
        end
    endtask

    task automatic burst(input logic we, input int a, input int beats, input logic [NB-1:0] be);
        cmd(1'b1, we, a, be);
        for (int i = 1; i < beats; i++) cmd(1'b0, we, 0, be);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    initial begin
        #(200000 * 10);
        n_err++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mmem[i] = '0;
        for (int m = 0; m < 2; m++) begin
            // R11: reset state, bus released
            cur_req = "R11";
            r_rst_n = 1'b0; r_flow = m[0]; r_ilv = 1'b0; r_oe = 1'b1; r_sleep = 1'b0;
            idle(3);
            r_rst_n = 1'b1;
            idle(2);

            // R3: fill every word with single writes
            cur_req = "R3";
            for (int a = 0; a < DEPTH; a++) cmd(1'b1, 1'b1, a, 2'b11);
            idle(3);

            // R2: single and back-to-back reads
            cur_req = "R2";
            cmd(1'b1, 1'b0, 5, 2'b00); idle(3);
            cmd(1'b1, 1'b0, 63, 2'b00); idle(2);
            for (int a = 16; a < 24; a++) cmd(1'b1, 1'b0, a, 2'b00);
            idle(3);

            // R4: read and write alternate with no gap
            cur_req = "R4";
            for (int i = 0; i < 12; i++) cmd(1'b1, i[0], (i * 7) % DEPTH, 2'b11);
            for (int i = 0; i < 6; i++) cmd(1'b1, (i < 3), 33 + i, 2'b11);
            idle(3);

            // R8: read right behind a write to the same word
            cur_req = "R8";
            cmd(1'b1, 1'b1, 10, 2'b11); cmd(1'b1, 1'b0, 10, 2'b00);
            cmd(1'b1, 1'b1, 11, 2'b01); cmd(1'b1, 1'b0, 11, 2'b00);
            cmd(1'b1, 1'b1, 12, 2'b10); cmd(1'b1, 1'b0, 20, 2'b00);
            cmd(1'b1, 1'b0, 12, 2'b00);
            idle(3);

            // R7: byte-masked writes then read back
            cur_req = "R7";
            cmd(1'b1, 1'b1, 30, 2'b01); cmd(1'b1, 1'b1, 31, 2'b10);
            cmd(1'b1, 1'b1, 32, 2'b00);
            idle(3);
            for (int a = 30; a < 33; a++) cmd(1'b1, 1'b0, a, 2'b00);
            idle(3);

            // R5: linear bursts, including a wrap past four beats
            cur_req = "R5";
            r_ilv = 1'b0;
            burst(1'b0, 6, 6, 2'b00); idle(3);
            burst(1'b1, 41, 4, 2'b11); idle(3);
            burst(1'b0, 40, 4, 2'b00); idle(3);
            burst(1'b1, 46, 4, 2'b01); burst(1'b0, 47, 4, 2'b00); idle(3);

            // R6: interleaved bursts
            cur_req = "R6";
            r_ilv = 1'b1;
            burst(1'b0, 6, 4, 2'b00); idle(3);
            burst(1'b1, 13, 4, 2'b11); idle(3);
            burst(1'b0, 12, 5, 2'b00); idle(3);
            r_ilv = 1'b0;
            burst(1'b0, 13, 4, 2'b00); idle(3);

            // R1: deselected loads and an advance while idle
            cur_req = "R1";
            r_csa_n = 1'b1; r_csb = 1'b1; r_csc_n = 1'b0; r_adv = 1'b0; r_wr = 1'b1; r_addr = 6'd50; r_bwe = 2'b11; advance();
            r_csa_n = 1'b0; r_csb = 1'b0; r_csc_n = 1'b0; r_addr = 6'd51; advance();
            r_csa_n = 1'b0; r_csb = 1'b1; r_csc_n = 1'b1; r_addr = 6'd52; advance();
            r_csc_n = 1'b1; r_wr = 1'b0; r_addr = 6'd0; advance();
            idle(2);
            r_csa_n = 1'b0; r_csb = 1'b1; r_csc_n = 1'b0; r_adv = 1'b1; r_wr = 1'b1; advance(); advance();
            idle(3);
            for (int a = 50; a < 53; a++) cmd(1'b1, 1'b0, a, 2'b00);
            idle(3);

            // R9: output enable toggled while read data is due
            cur_req = "R9";
            for (int i = 0; i < 6; i++) begin
                r_oe = i[0];
                cmd(1'b1, 1'b0, i, 2'b00);
            end
            r_oe = 1'b0; idle(1); r_oe = 1'b1; idle(1); r_oe = 1'b0; idle(1);
            r_oe = 1'b1; idle(2);

            // R10: sleep ignores commands and releases the bus
            cur_req = "R10";
            cmd(1'b1, 1'b0, 5, 2'b00);
            r_sleep = 1'b1;
            cmd(1'b1, 1'b1, 60, 2'b11);
            cmd(1'b1, 1'b0, 60, 2'b00);
            cmd(1'b1, 1'b0, 7, 2'b00);
            r_sleep = 1'b0;
            cmd(1'b1, 1'b1, 61, 2'b11);
            r_sleep = 1'b1; idle(3);
            r_sleep = 1'b0; idle(1);
            cmd(1'b1, 1'b0, 60, 2'b00); cmd(1'b1, 1'b0, 61, 2'b00);
            idle(3);

            // R11: reset discards a pending write
            cur_req = "R11";
            cmd(1'b1, 1'b1, 62, 2'b11);
            r_rst_n = 1'b0; idle(2);
            r_rst_n = 1'b1; idle(1);
            cmd(1'b1, 1'b0, 62, 2'b00);
            idle(3);
        end
        summary();
        $finish;
    end
endmodule